// File: doc/BRIEF.md
# Palette Colour-Lookup Register Port

This block is the colour table behind an 8-bit pseudocolour display. It stores 256 normal colour entries and a small bank of 4 overlay entries (used for cursor colours). Each entry holds one byte each of red, green and blue. Software reaches the table through a 32-bit register bus. It first writes an entry number into an index register. It then moves the three colour bytes of that entry, one per access, through a single data port. The block keeps track of which component comes next and steps to the following entry on its own once blue has been moved.

A second data port reaches the overlay bank. It uses the same red/green/blue stepping, and the entry it targets is picked by the two low bits of the shared index. On the pixel side, a lookup port takes a 9-bit entry number (0 to 255 normal, 256 to 259 overlay) and returns the 24-bit colour of that entry one clock later.

Top module: `palette_dac`

## Requirements
- R1: After synchronous reset every colour byte is zero, except entries 255, 256 and 258, which are white (all three bytes 0xFF). The index and the component phase are both zero, so the next data access touches red of entry 0. Both outputs read zero while reset is held.
- R2: A bus write at byte offset 0 loads the index from write-data bits 31:24, and the other bits are ignored. It also sets the phase to red.
- R3: Bus writes at offset 4 store write-data bits 31:24 into the normal entry selected by the index. Successive writes fill red, then green, then blue.
- R4: The access that moves the blue component increments the index modulo 256 (255 wraps to 0) and returns the phase to red. This applies to a write at offset 4, a write at offset 12 and a read at offset 4.
- R5: Bus writes at offset 12 store into overlay entry 256 + index[1:0], using the same phase sequence as offset 4. They also advance the same shared index and phase.
- R6: A bus read at offset 4 returns the current component of the indexed normal entry in bits 31:24, with bits 23:0 zero. It advances the phase exactly as a write does. The data is on `reg_rdata` in the cycle after the access.
- R7: In any cycle that follows something other than a read at offset 4, `reg_rdata` is zero. This covers idle cycles, writes and reads at other offsets. A read at any other offset leaves the index and the phase unchanged.
- R8: Writes at any offset other than 0, 4 and 12 change neither the table, the index nor the phase.
- R9: `pix_rgb` shows the colour of entry `pix_entry`, packed as {red, green, blue}, one cycle after the entry number is presented. Entry numbers 260 and above give zero.
- R10: An index write in the middle of a red/green/blue sequence discards the partial sequence. The next data write goes to red of the newly loaded entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_valid | input | 1 | Bus access in this cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| pix_entry | input | 9 | Entry number to look up |
| pix_rgb | output | 24 | Looked-up colour {red, green, blue}, registered |

## Verification
Both results are registered. Read data for an access presented in cycle N, and the colour for an entry number presented in cycle N, are both due in cycle N+1. Every stimulus task stamps its expected item with the cycle count plus one. The monitor compares an item only when the cycle count reaches that stamp, sampling on the falling edge. Every bus cycle, including writes and idle lookups, queues an expected read-data value, so the zero-when-not-reading rule is checked throughout. The colour expectations come from a byte-array model of the table that the driver updates as it issues each access.

// File: rtl/pal_pkg.sv
`timescale 1ns/1ps
package pal_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned COMP_W = 8;
    localparam int unsigned N_NORM = 256;
    localparam int unsigned N_OVL  = 4;
    localparam int unsigned ADDR_W = 4;

    localparam int unsigned N_ENT  = N_NORM + N_OVL;
    localparam int unsigned IDX_W  = $clog2(N_NORM);
    localparam int unsigned OVL_W  = $clog2(N_OVL);
    localparam int unsigned ENT_W  = $clog2(N_ENT);
    localparam int unsigned RGB_W  = 3 * COMP_W;

    localparam logic [ADDR_W-1:0] OFS_INDEX = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_DATA  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] OFS_OVL   = ADDR_W'(12);

    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_e;

    typedef struct packed {
        logic [COMP_W-1:0] r;
        logic [COMP_W-1:0] g;
        logic [COMP_W-1:0] b;
    } rgb_t;

    // Entries that come out of reset white: last normal, first and third overlay.
    function automatic rgb_t reset_color(int unsigned e);
        rgb_t c;
        if (e == N_NORM - 1 || e == N_NORM || e == N_NORM + 2)
            c = '{r: '1, g: '1, b: '1};
        else
            c = '0;
        return c;
    endfunction

    function automatic logic [COMP_W-1:0] pick(rgb_t c, phase_e p);
        case (p)
            PH_RED:  return c.r;
            PH_GRN:  return c.g;
            default: return c.b;
        endcase
    endfunction

    function automatic phase_e next_phase(phase_e p);
        case (p)
            PH_RED:  return PH_GRN;
            PH_GRN:  return PH_BLU;
            default: return PH_RED;
        endcase
    endfunction

endpackage

// File: rtl/pal_seq.sv
`timescale 1ns/1ps
module pal_seq
    import pal_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [IDX_W-1:0] load_idx,
    input  logic             step,
    output logic [IDX_W-1:0] idx_q,
    output phase_e           phase_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= '0;
            phase_q <= PH_RED;
        end else if (load) begin
            idx_q   <= load_idx;
            phase_q <= PH_RED;
        end else if (step) begin
            if (phase_q == PH_BLU) begin
                idx_q   <= idx_q + 1'b1;
                phase_q <= PH_RED;
            end else begin
                phase_q <= next_phase(phase_q);
            end
        end
    end

endmodule

// File: rtl/pal_store.sv
`timescale 1ns/1ps
module pal_store
    import pal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ENT_W-1:0]  wr_entry,
    input  phase_e            wr_comp,
    input  logic [COMP_W-1:0] wr_byte,
    input  logic [IDX_W-1:0]  a_entry,
    input  phase_e            a_comp,
    output logic [COMP_W-1:0] a_byte,
    input  logic [ENT_W-1:0]  b_entry,
    output rgb_t              b_rgb
);

    rgb_t mem [N_ENT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < N_ENT; e++)
                mem[e] <= reset_color(e);
        end else if (wr_en) begin
            case (wr_comp)
                PH_RED:  mem[wr_entry].r <= wr_byte;
                PH_GRN:  mem[wr_entry].g <= wr_byte;
                default: mem[wr_entry].b <= wr_byte;
            endcase
        end
    end

    always_comb begin
        a_byte = pick(mem[a_entry], a_comp);
        if (b_entry < ENT_W'(N_ENT))
            b_rgb = mem[b_entry];
        else
            b_rgb = '0;
    end

endmodule

// File: rtl/palette_dac.sv
`timescale 1ns/1ps
module palette_dac
    import pal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_valid,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [ENT_W-1:0]  pix_entry,
    output logic [RGB_W-1:0]  pix_rgb
);

    logic             hit_index, hit_data, hit_ovl, step, rd_hit, wr_en;
    logic [IDX_W-1:0] idx_q;
    phase_e           phase_q;
    logic [ENT_W-1:0] wr_entry;
    logic [COMP_W-1:0] a_byte;
    rgb_t             b_rgb;

    always_comb begin
        hit_index = reg_valid && reg_we && (reg_addr == OFS_INDEX);
        hit_data  = reg_valid && (reg_addr == OFS_DATA);
        hit_ovl   = reg_valid && reg_we && (reg_addr == OFS_OVL);
        step      = hit_data || hit_ovl;
        wr_en     = reg_we && step;
        rd_hit    = hit_data && !reg_we;
        if (hit_ovl)
            wr_entry = ENT_W'(N_NORM) + ENT_W'(idx_q[OVL_W-1:0]);
        else
            wr_entry = ENT_W'(idx_q);
    end

    pal_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .load     (hit_index),
        .load_idx (reg_wdata[DATA_W-1 -: IDX_W]),
        .step     (step),
        .idx_q    (idx_q),
        .phase_q  (phase_q)
    );

    pal_store u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_entry (wr_entry),
        .wr_comp  (phase_q),
        .wr_byte  (reg_wdata[DATA_W-1 -: COMP_W]),
        .a_entry  (idx_q),
        .a_comp   (phase_q),
        .a_byte   (a_byte),
        .b_entry  (pix_entry),
        .b_rgb    (b_rgb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
            pix_rgb   <= '0;
        end else begin
            reg_rdata <= rd_hit ? {a_byte, {(DATA_W-COMP_W){1'b0}}} : '0;
            pix_rgb   <= b_rgb;
        end
    end

endmodule

// File: rtl/pal_dac_chk.sv
`timescale 1ns/1ps
module pal_dac_chk
    import pal_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_valid,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [ENT_W-1:0]  pix_entry,
    input logic [RGB_W-1:0]  pix_rgb,
    input logic [IDX_W-1:0]  idx_q,
    input phase_e            phase_q
);

    logic rd_now, wr_other;
    always_comb begin
        rd_now   = reg_valid && !reg_we && (reg_addr == OFS_DATA);
        wr_other = reg_valid && reg_we && (reg_addr != OFS_INDEX)
                   && (reg_addr != OFS_DATA) && (reg_addr != OFS_OVL);
    end

    // R2
    index_load_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_valid && reg_we && reg_addr == OFS_INDEX)
        |=> (idx_q == $past(reg_wdata[DATA_W-1 -: IDX_W]) && phase_q == PH_RED));

    // R4
    blue_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_valid && phase_q == PH_BLU &&
         (reg_addr == OFS_DATA || (reg_we && reg_addr == OFS_OVL)))
        |=> (idx_q == $past(idx_q) + 1'b1 && phase_q == PH_RED));

    // R6
    read_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_now |=> (reg_rdata[DATA_W-COMP_W-1:0] == '0));

    // R7
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_now |=> (reg_rdata == '0));

    // R8
    ignored_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_other |=> ($stable(idx_q) && $stable(phase_q)));

    // R9
    pix_range_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_entry >= ENT_W'(N_ENT)) |=> (pix_rgb == '0));

endmodule

bind palette_dac pal_dac_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_valid (reg_valid),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pix_entry (pix_entry),
    .pix_rgb   (pix_rgb),
    .idx_q     (idx_q),
    .phase_q   (phase_q)
);

// File: tb/palette_dac_test.sv
`timescale 1ns/1ps
module palette_dac_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_valid = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [8:0]  pix_entry = '0;
    logic [23:0] pix_rgb;

    always #2.5 clk = ~clk;

    palette_dac uut (
        .clk       (clk),
        .rst       (rst),
        .reg_valid (reg_valid),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pix_entry (pix_entry),
        .pix_rgb   (pix_rgb)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Reference table built from the requirements.
    logic [7:0] m_r [260];
    logic [7:0] m_g [260];
    logic [7:0] m_b [260];
    int m_idx = 0;
    int m_ph  = 0;

    // Scoreboard queues.
    int          q_due  [$];
    bit          q_pix  [$];
    logic [31:0] q_val  [$];
    string       q_tag  [$];

    logic [31:0] act_v, exp_v;
    string       tag_v;
    bit          pix_v;

    task automatic push(bit is_pix, logic [31:0] v, string tag);
        q_due.push_back(cyc + 1);
        q_pix.push_back(is_pix);
        q_val.push_back(v);
        q_tag.push_back(tag);
    endtask

    always @(negedge clk) begin
        while (q_due.size() > 0 && q_due[0] == cyc) begin
            void'(q_due.pop_front());
            pix_v = q_pix.pop_front();
            exp_v = q_val.pop_front();
            tag_v = q_tag.pop_front();
            act_v = pix_v ? {8'h00, pix_rgb} : reg_rdata;
            checks++;
            if (act_v !== exp_v) begin
                failures++;
                $display("FAIL %s %s actual=%h expected=%h", tag_v,
                         pix_v ? "pix_rgb" : "reg_rdata", act_v, exp_v);
            end
        end
    end

    function automatic logic [23:0] model_rgb(int e);
        if (e >= 260) return 24'h0;
        return {m_r[e], m_g[e], m_b[e]};
    endfunction

    task automatic bus(logic w, logic [3:0] a, logic [31:0] d, string tag);
        logic [31:0] ex;
        int ent;
        @(negedge clk);
        reg_valid = 1'b1;
        reg_we    = w;
        reg_addr  = a;
        reg_wdata = d;
        ex = 32'h0;
        if (w && a == 4'd0) begin
            m_idx = int'(d[31:24]);
            m_ph  = 0;
        end else if (a == 4'd4 || (w && a == 4'd12)) begin
            ent = (a == 4'd12) ? 256 + (m_idx % 4) : m_idx;
            if (w) begin
                if (m_ph == 0) m_r[ent] = d[31:24];
                else if (m_ph == 1) m_g[ent] = d[31:24];
                else m_b[ent] = d[31:24];
            end else begin
                if (m_ph == 0) ex = {m_r[ent], 24'h0};
                else if (m_ph == 1) ex = {m_g[ent], 24'h0};
                else ex = {m_b[ent], 24'h0};
            end
            if (m_ph == 2) begin
                m_idx = (m_idx + 1) % 256;
                m_ph  = 0;
            end else begin
                m_ph = m_ph + 1;
            end
        end
        push(1'b0, ex, tag);
    endtask

    task automatic look(int e, string tag);
        @(negedge clk);
        reg_valid = 1'b0;
        reg_we    = 1'b0;
        pix_entry = 9'(e);
        push(1'b0, 32'h0, "R7");
        push(1'b1, {8'h00, model_rgb(e)}, tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int e = 0; e < 260; e++) begin
            m_r[e] = 8'h00; m_g[e] = 8'h00; m_b[e] = 8'h00;
        end
        foreach (m_r[e]) if (e == 255 || e == 256 || e == 258) begin
            m_r[e] = 8'hFF; m_g[e] = 8'hFF; m_b[e] = 8'hFF;
        end

        repeat (3) @(negedge clk);
        // R1: outputs zero during reset
        checks++;
        if (reg_rdata !== 32'h0 || pix_rgb !== 24'h0) begin
            failures++;
            $display("FAIL R1 reset outputs actual=%h/%h expected=0/0", reg_rdata, pix_rgb);
        end
        rst = 1'b0;

        // R1: reset contents of the table
        look(0, "R1"); look(255, "R1"); look(256, "R1");
        look(257, "R1"); look(258, "R1"); look(259, "R1");
        // R1 / R6: first reads start at red of entry 0
        bus(0, 4'd4, 32'h0, "R6"); bus(0, 4'd4, 32'h0, "R6"); bus(0, 4'd4, 32'h0, "R6");

        // R2, R3: index load with low-bit noise, then three component writes
        bus(1, 4'd0, 32'h05ABCDEF, "R2");
        bus(1, 4'd4, 32'h11FFFFFF, "R3");
        bus(1, 4'd4, 32'h22000001, "R3");
        bus(1, 4'd4, 32'h33123456, "R3");
        look(5, "R3"); look(6, "R3");

        // R6, R7: read back with other-offset reads interleaved
        bus(1, 4'd0, 32'h05000000, "R2");
        bus(0, 4'd4, 32'h0, "R6");
        bus(0, 4'd0, 32'h0, "R7");
        bus(0, 4'd12, 32'h0, "R7");
        bus(0, 4'd8, 32'h0, "R7");
        bus(0, 4'd4, 32'h0, "R6");
        bus(0, 4'd4, 32'h0, "R6");
        // R6: phase shared between reads and writes
        bus(0, 4'd4, 32'h0, "R6");
        bus(1, 4'd4, 32'h7A000000, "R6");
        bus(1, 4'd4, 32'h7B000000, "R6");
        look(6, "R6");

        // R10: index rewrite mid-sequence
        bus(1, 4'd0, 32'h09000000, "R10");
        bus(1, 4'd4, 32'h44000000, "R10");
        bus(1, 4'd0, 32'h09000000, "R10");
        bus(1, 4'd4, 32'h55000000, "R10");
        bus(1, 4'd4, 32'h66000000, "R10");
        bus(1, 4'd4, 32'h77000000, "R10");
        look(9, "R10");

        // R4: wrap from 255 to 0
        bus(1, 4'd0, 32'hFF000000, "R4");
        bus(1, 4'd4, 32'h01000000, "R4");
        bus(1, 4'd4, 32'h02000000, "R4");
        bus(1, 4'd4, 32'h03000000, "R4");
        bus(1, 4'd4, 32'h99000000, "R4");
        look(255, "R4"); look(0, "R4");

        // R5: overlay writes use index[1:0] and step the shared index
        bus(1, 4'd0, 32'h06000000, "R5");
        bus(1, 4'd12, 32'hA0000000, "R5");
        bus(1, 4'd12, 32'hA1000000, "R5");
        bus(1, 4'd12, 32'hA2000000, "R5");
        bus(1, 4'd4, 32'hB0000000, "R5");
        bus(1, 4'd4, 32'hB1000000, "R5");
        bus(1, 4'd4, 32'hB2000000, "R5");
        look(258, "R5"); look(7, "R5"); look(6, "R5");
        bus(1, 4'd0, 32'hFF000000, "R5");
        bus(1, 4'd12, 32'hC0000000, "R5");
        bus(1, 4'd12, 32'hC1000000, "R5");
        bus(1, 4'd12, 32'hC2000000, "R5");
        bus(0, 4'd4, 32'h0, "R5");
        look(259, "R5"); look(255, "R5");

        // R8: writes at unused offsets change nothing
        bus(1, 4'd0, 32'h14000000, "R8");
        bus(1, 4'd4, 32'hD1000000, "R8");
        bus(1, 4'd8, 32'hDEADBEEF, "R8");
        bus(1, 4'd1, 32'h0F0F0F0F, "R8");
        bus(1, 4'd15, 32'hFFFFFFFF, "R8");
        bus(1, 4'd4, 32'hD2000000, "R8");
        bus(1, 4'd4, 32'hD3000000, "R8");
        look(20, "R8"); look(21, "R8");

        // R9: out-of-range lookups
        look(260, "R9"); look(300, "R9"); look(511, "R9"); look(257, "R9");

        look(0, "R7");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule